// File: doc/BRIEF.md
# Hash-Based Receive Queue Distributor

This block spreads received flows across a contiguous group of frame queues. Each cycle it can accept one set of parsed header fields: IPv4 source and destination address, L4 source and destination port, and IPsec SPI. Each field comes with its own presence flag. The block builds a fixed 128-bit key from these fields and runs a 64-bit CRC over it. It then picks 24 bits of that hash with a configurable right shift, masks them down to the size of the queue group, and merges the result into a queue base. A parser upstream supplies the fields. The queue number goes to an enqueue stage downstream.

When a field is missing, the block puts a configured default in its place, so frames without L3 or L4 headers still land on a fixed queue. A symmetric option puts each source/destination pair in a canonical order before hashing. With it set, both directions of a connection map to the same queue.

The select word, both default words, the hash command and the queue base are all sampled in the same cycle as the key. Configuration can therefore change from one key to the next.

Top module: `hrq_distributor`

## Requirements
- R1: While reset is asserted and until the first key has passed through, `out_valid` is 0 and `out_queue` is 0.
- R2: Every cycle with `in_valid` high gives exactly one cycle with `out_valid` high, two clock edges later. Keys may arrive back to back, and results leave in the order the keys arrived. Between results, `out_queue` holds its last value.
- R3: The hash is CRC-64 with polynomial 0x42F0E1EBA9EA3693, initial value 0, no reflection and no final XOR. It runs over the 128-bit key {ip_src, ip_dst, l4_src, l4_dst, spi}, most significant bit first.
- R4: A missing IP address (its `_ok` flag is 0) takes its value from `dflt_select[19:18]`. Code 2 selects `dflt_word0`, code 3 selects `dflt_word1`, and codes 0 and 1 give zero. The value on the missing field's data input has no effect.
- R5: A missing L4 port takes its value from the low 16 bits of the word that `dflt_select[9:8]` picks, using the same codes as R4.
- R6: A missing SPI is replaced by zero.
- R7: `hash_cmd[29:24]` is a right shift of 0 to 63 applied to the 64-bit hash. The low 24 bits of the shifted value are used, so bits that are shifted out read as zero.
- R8: `hash_cmd[23:0]` is the queue mask, equal to the queue count minus 1. The output is `queue_base | (shifted_hash[23:0] & mask)`. For a base aligned to the queue count, the bits outside the mask equal the base.
- R9: When `hash_cmd[30]` is 1, each address pair and each port pair is reordered so that the smaller value comes first. This happens after default substitution. The result is that swapping source and destination gives the same queue.
- R10: The select word, default words, hash command and queue base only affect the key presented in the same cycle. Changing them later does not alter a result that is already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A key is presented this cycle |
| ip_src | input | 32 | IPv4 source address |
| ip_src_ok | input | 1 | Source address present |
| ip_dst | input | 32 | IPv4 destination address |
| ip_dst_ok | input | 1 | Destination address present |
| l4_src | input | 16 | L4 source port |
| l4_src_ok | input | 1 | Source port present |
| l4_dst | input | 16 | L4 destination port |
| l4_dst_ok | input | 1 | Destination port present |
| spi | input | 32 | IPsec SPI |
| spi_ok | input | 1 | SPI present |
| dflt_word0 | input | 32 | Default word 0 |
| dflt_word1 | input | 32 | Default word 1 |
| dflt_select | input | 32 | Default select codes (bits 19:18 addresses, 9:8 ports) |
| hash_cmd | input | 32 | Mask [23:0], shift [29:24], symmetric [30] |
| queue_base | input | 24 | Base queue number, aligned to the queue count |
| out_valid | output | 1 | Result strobe |
| out_queue | output | 24 | Selected queue number |

## Verification
An error in the key assembly, whether in a default choice or in the symmetric ordering, changes the CRC input. With a wide mask and shifts that expose many hash bits, it then shows up as a wrong `out_queue` in the very result that used the bad key, two cycles after the key was accepted.

An error in the pipeline's valid or configuration staging works differently. A lost or extra strobe, or configuration captured in the wrong cycle, puts the stream of results out of step with the stream of keys. The scoreboard sees this as a mismatch or an unexpected strobe at the next result, or as leftover expected items once the stream has drained.

// File: rtl/hrqd_pkg.sv
package hrqd_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned PORT_W  = 16;
  localparam int unsigned SPI_W   = 32;
  localparam int unsigned KEY_W   = 2 * ADDR_W + 2 * PORT_W + SPI_W;
  localparam int unsigned HASH_W  = 64;

  // select-word field positions and codes
  localparam int unsigned IP_SEL_LSB = 18;
  localparam int unsigned L4_SEL_LSB = 8;
  localparam logic [1:0]  SEL_WORD0  = 2'd2;
  localparam logic [1:0]  SEL_WORD1  = 2'd3;

  // hash command field positions
  localparam int unsigned SHIFT_LSB = 24;
  localparam int unsigned SHIFT_W   = 6;
  localparam int unsigned SYM_BIT   = 30;

  typedef struct packed {
    logic [ADDR_W-1:0] addr_a;
    logic [ADDR_W-1:0] addr_b;
    logic [PORT_W-1:0] port_a;
    logic [PORT_W-1:0] port_b;
    logic [SPI_W-1:0]  spi;
  } flow_key_t;

  function automatic logic [31:0] pick_default(input logic [1:0] code,
                                               input logic [31:0] w0,
                                               input logic [31:0] w1);
    logic [31:0] r;
    case (code)
      SEL_WORD0: r = w0;
      SEL_WORD1: r = w1;
      default:   r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hrqd_key_assemble.sv
module hrqd_key_assemble
  import hrqd_pkg::*;
(
  input  logic [ADDR_W-1:0] ip_src,
  input  logic              ip_src_ok,
  input  logic [ADDR_W-1:0] ip_dst,
  input  logic              ip_dst_ok,
  input  logic [PORT_W-1:0] l4_src,
  input  logic              l4_src_ok,
  input  logic [PORT_W-1:0] l4_dst,
  input  logic              l4_dst_ok,
  input  logic [SPI_W-1:0]  spi,
  input  logic              spi_ok,
  input  logic [31:0]       dflt_word0,
  input  logic [31:0]       dflt_word1,
  input  logic [1:0]        ip_code,
  input  logic [1:0]        l4_code,
  input  logic              symmetric,
  output flow_key_t         key
);
  logic [31:0]       ip_fill;
  logic [31:0]       l4_fill_word;
  logic [PORT_W-1:0] l4_fill;
  logic [ADDR_W-1:0] a_src, a_dst;
  logic [PORT_W-1:0] p_src, p_dst;
  logic              swap_addr, swap_port;
  logic [31:0]       unused_fill_hi;

  always_comb begin
    ip_fill      = pick_default(ip_code, dflt_word0, dflt_word1);
    l4_fill_word = pick_default(l4_code, dflt_word0, dflt_word1);
    l4_fill      = l4_fill_word[PORT_W-1:0];
  end

  assign unused_fill_hi = {l4_fill_word[31:PORT_W], {PORT_W{1'b0}}};

  always_comb begin
    a_src = ip_src_ok ? ip_src : ip_fill[ADDR_W-1:0];
    a_dst = ip_dst_ok ? ip_dst : ip_fill[ADDR_W-1:0];
    p_src = l4_src_ok ? l4_src : l4_fill;
    p_dst = l4_dst_ok ? l4_dst : l4_fill;
  end

  always_comb begin
    swap_addr   = symmetric && (a_src > a_dst);
    swap_port   = symmetric && (p_src > p_dst);
    key.addr_a  = swap_addr ? a_dst : a_src;
    key.addr_b  = swap_addr ? a_src : a_dst;
    key.port_a  = swap_port ? p_dst : p_src;
    key.port_b  = swap_port ? p_src : p_dst;
    key.spi     = spi_ok ? spi : '0;
  end
endmodule

// File: rtl/hrqd_crc64.sv
module hrqd_crc64 #(
  parameter int unsigned  KEY_BITS = 128,
  parameter int unsigned  CRC_W    = 64,
  parameter logic [63:0]  POLY     = 64'h42F0_E1EB_A9EA_3693
) (
  input  logic [KEY_BITS-1:0] key,
  output logic [CRC_W-1:0]    crc
);
  logic [CRC_W-1:0] chain [0:KEY_BITS];

  assign chain[0] = '0;

  // one bit-serial CRC step per key bit, most significant bit first
  for (genvar g = 0; g < KEY_BITS; g++) begin : g_step
    logic fb;
    assign fb = chain[g][CRC_W-1] ^ key[KEY_BITS-1-g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
  end

  assign crc = chain[KEY_BITS];
endmodule

// File: rtl/hrqd_queue_select.sv
module hrqd_queue_select #(
  parameter int unsigned HASH_BITS = 64,
  parameter int unsigned QID_W     = 24,
  parameter int unsigned SH_W      = 6
) (
  input  logic [HASH_BITS-1:0] hash,
  input  logic [SH_W-1:0]      shift,
  input  logic [QID_W-1:0]     mask,
  input  logic [QID_W-1:0]     base,
  output logic [QID_W-1:0]     qid
);
  logic [HASH_BITS-1:0] shifted;
  logic [HASH_BITS-1:0] unused_shifted_hi;

  assign shifted           = hash >> shift;
  assign unused_shifted_hi = {shifted[HASH_BITS-1:QID_W], {QID_W{1'b0}}};
  assign qid               = base | (shifted[QID_W-1:0] & mask);
endmodule

// File: rtl/hrq_distributor.sv
module hrq_distributor
  import hrqd_pkg::*;
#(
  parameter int unsigned QID_W = 24,
  parameter logic [63:0] POLY  = 64'h42F0_E1EB_A9EA_3693
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       ip_src,
  input  logic              ip_src_ok,
  input  logic [31:0]       ip_dst,
  input  logic              ip_dst_ok,
  input  logic [15:0]       l4_src,
  input  logic              l4_src_ok,
  input  logic [15:0]       l4_dst,
  input  logic              l4_dst_ok,
  input  logic [31:0]       spi,
  input  logic              spi_ok,
  input  logic [31:0]       dflt_word0,
  input  logic [31:0]       dflt_word1,
  input  logic [31:0]       dflt_select,
  input  logic [31:0]       hash_cmd,
  input  logic [QID_W-1:0]  queue_base,
  output logic              out_valid,
  output logic [QID_W-1:0]  out_queue
);
  flow_key_t          key_c;
  flow_key_t          s1_key_q, s1_key_d;
  logic               s1_vld_q, s1_vld_d;
  logic [SHIFT_W-1:0] s1_shift_q, s1_shift_d;
  logic [QID_W-1:0]   s1_mask_q, s1_mask_d;
  logic [QID_W-1:0]   s1_base_q, s1_base_d;
  logic [HASH_W-1:0]  hash_c;
  logic [QID_W-1:0]   qid_c;
  logic               o_vld_q, o_vld_d;
  logic [QID_W-1:0]   o_qid_q, o_qid_d;
  logic [31:0]        unused_cfg;

  assign unused_cfg = {hash_cmd[31], dflt_select[31:20], dflt_select[17:10],
                       dflt_select[7:0], 3'b0};

  hrqd_key_assemble u_key (
    .ip_src     (ip_src),
    .ip_src_ok  (ip_src_ok),
    .ip_dst     (ip_dst),
    .ip_dst_ok  (ip_dst_ok),
    .l4_src     (l4_src),
    .l4_src_ok  (l4_src_ok),
    .l4_dst     (l4_dst),
    .l4_dst_ok  (l4_dst_ok),
    .spi        (spi),
    .spi_ok     (spi_ok),
    .dflt_word0 (dflt_word0),
    .dflt_word1 (dflt_word1),
    .ip_code    (dflt_select[IP_SEL_LSB +: 2]),
    .l4_code    (dflt_select[L4_SEL_LSB +: 2]),
    .symmetric  (hash_cmd[SYM_BIT]),
    .key        (key_c)
  );

  // stage 1: capture key and per-key configuration
  always_comb begin
    s1_vld_d   = in_valid;
    s1_key_d   = s1_key_q;
    s1_shift_d = s1_shift_q;
    s1_mask_d  = s1_mask_q;
    s1_base_d  = s1_base_q;
    if (in_valid) begin
      s1_key_d   = key_c;
      s1_shift_d = hash_cmd[SHIFT_LSB +: SHIFT_W];
      s1_mask_d  = hash_cmd[QID_W-1:0];
      s1_base_d  = queue_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld_q <= 1'b0;
    else        s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_key_q   <= s1_key_d;
      s1_shift_q <= s1_shift_d;
      s1_mask_q  <= s1_mask_d;
      s1_base_q  <= s1_base_d;
    end
  end

  hrqd_crc64 #(
    .KEY_BITS (KEY_W),
    .CRC_W    (HASH_W),
    .POLY     (POLY)
  ) u_crc (
    .key (s1_key_q),
    .crc (hash_c)
  );

  hrqd_queue_select #(
    .HASH_BITS (HASH_W),
    .QID_W     (QID_W),
    .SH_W      (SHIFT_W)
  ) u_sel (
    .hash  (hash_c),
    .shift (s1_shift_q),
    .mask  (s1_mask_q),
    .base  (s1_base_q),
    .qid   (qid_c)
  );

  // stage 2: result register
  always_comb begin
    o_vld_d = s1_vld_q;
    o_qid_d = s1_vld_q ? qid_c : o_qid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld_q <= 1'b0;
      o_qid_q <= '0;
    end else begin
      o_vld_q <= o_vld_d;
      if (s1_vld_q) o_qid_q <= o_qid_d;
    end
  end

  assign out_valid = o_vld_q;
  assign out_queue = o_qid_q;
endmodule

// File: rtl/hrqd_checker.sv
module hrqd_checker #(
  parameter int unsigned QID_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      hash_cmd,
  input logic [QID_W-1:0] queue_base,
  input logic             out_valid,
  input logic [QID_W-1:0] out_queue
);
  // R2
  lat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R2
  lat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_queue));

  // R8
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_queue ^ $past(queue_base, 2)) &
                    ~$past(hash_cmd[QID_W-1:0], 2)) == '0));

  // R7
  max_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(hash_cmd[29:24], 2) == 6'd63) |->
      (out_queue[QID_W-1:1] == $past(queue_base[QID_W-1:1], 2)));
endmodule

bind hrq_distributor hrqd_checker #(.QID_W(QID_W)) u_hrqd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .hash_cmd   (hash_cmd),
  .queue_base (queue_base),
  .out_valid  (out_valid),
  .out_queue  (out_queue)
);

// File: tb/tb_hrq_distributor.sv
module tb_hrq_distributor;
  typedef struct packed {
    logic [31:0] ips;  logic ips_ok;
    logic [31:0] ipd;  logic ipd_ok;
    logic [15:0] ps;   logic ps_ok;
    logic [15:0] pd;   logic pd_ok;
    logic [31:0] sp;   logic sp_ok;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [31:0] sel;
    logic [31:0] cmd;
    logic [23:0] base;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  stim_t cur = '0;
  logic out_valid;
  logic [23:0] out_queue;

  int total = 0;
  int bad = 0;
  int sent = 0;
  int got = 0;
  logic [23:0] expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  hrq_distributor dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .ip_src(cur.ips), .ip_src_ok(cur.ips_ok),
    .ip_dst(cur.ipd), .ip_dst_ok(cur.ipd_ok),
    .l4_src(cur.ps), .l4_src_ok(cur.ps_ok),
    .l4_dst(cur.pd), .l4_dst_ok(cur.pd_ok),
    .spi(cur.sp), .spi_ok(cur.sp_ok),
    .dflt_word0(cur.d0), .dflt_word1(cur.d1), .dflt_select(cur.sel),
    .hash_cmd(cur.cmd), .queue_base(cur.base),
    .out_valid(out_valid), .out_queue(out_queue)
  );

  function automatic logic [31:0] fill(input logic [1:0] c, input logic [31:0] a,
                                       input logic [31:0] b);
    return (c == 2'd2) ? a : (c == 2'd3) ? b : 32'h0;
  endfunction

  function automatic logic [23:0] model(input stim_t s);
    logic [31:0] a, b, w, x;
    logic [15:0] p, q, t;
    logic [127:0] k;
    logic [63:0] c;
    logic fb;
    w = fill(s.sel[19:18], s.d0, s.d1);
    x = fill(s.sel[9:8], s.d0, s.d1);
    a = s.ips_ok ? s.ips : w;
    b = s.ipd_ok ? s.ipd : w;
    p = s.ps_ok ? s.ps : x[15:0];
    q = s.pd_ok ? s.pd : x[15:0];
    if (s.cmd[30]) begin
      if (a > b) begin w = a; a = b; b = w; end
      if (p > q) begin t = p; p = q; q = t; end
    end
    k = {a, b, p, q, (s.sp_ok ? s.sp : 32'h0)};
    c = '0;
    for (int i = 127; i >= 0; i--) begin
      fb = c[63] ^ k[i];
      c = {c[62:0], 1'b0};
      if (fb) c = c ^ 64'h42F0_E1EB_A9EA_3693;
    end
    c = c >> s.cmd[29:24];
    return s.base | (c[23:0] & s.cmd[23:0]);
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one key per call, valid for one cycle
  task automatic send(input stim_t s, input string req);
    @(negedge clk);
    cur = s;
    in_valid = 1'b1;
    expq.push_back(model(s));
    tagq.push_back(req);
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic stim_t rnd_stim();
    stim_t s;
    int lg;
    s = '0;
    s.ips = $urandom; s.ipd = $urandom; s.ps = 16'($urandom); s.pd = 16'($urandom);
    s.sp = $urandom;
    s.ips_ok = 1; s.ipd_ok = 1; s.ps_ok = 1; s.pd_ok = 1; s.sp_ok = 1;
    s.d0 = 32'h0A0A_0A0A; s.d1 = 32'h0B0B_0B0B;
    s.sel = (32'd2 << 18) | (32'd3 << 8);
    lg = $urandom_range(1, 12);
    s.cmd = {2'b00, 6'($urandom_range(0, 40)), 24'((1 << lg) - 1)};
    s.base = 24'($urandom_range(1, 255)) << lg;
    return s;
  endfunction

  // monitor: compare each result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got++;
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected strobe", out_queue, 24'h0);
      end else begin
        logic [23:0] e;
        string r;
        e = expq.pop_front();
        r = tagq.pop_front();
        check(out_queue == e, r, out_queue, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 24'h0, 24'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stim_t s, r;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid in reset", {23'h0, out_valid}, 24'h0);
    check(out_queue == 24'h0, "R1 queue in reset", out_queue, 24'h0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0 && out_queue == 24'h0, "R1 idle after reset",
          out_queue, 24'h0);

    // R3: all-zero key hashes to zero, result is the base
    s = '0;
    s.ips_ok = 1; s.ipd_ok = 1; s.ps_ok = 1; s.pd_ok = 1; s.sp_ok = 1;
    s.cmd = 32'h0000_00FF; s.base = 24'h000100;
    send(s, "R3 zero key");
    idle(1);
    check(model(s) == 24'h000100, "R3 zero-key expectation", model(s), 24'h000100);
    idle(3);

    // R2 R3 R7 R8: back-to-back varied keys
    for (int i = 0; i < 24; i++) send(rnd_stim(), "R3 R8 stream");
    idle(4);

    // R4 R5 R6: absent fields with every select code, garbage on data inputs
    for (int ic = 0; ic < 4; ic++)
      for (int lc = 0; lc < 4; lc++) begin
        s = rnd_stim();
        s.d0 = $urandom; s.d1 = $urandom;
        s.sel = 32'($urandom) & ~((32'd3 << 18) | (32'd3 << 8));
        s.sel = s.sel | (32'(ic) << 18) | (32'(lc) << 8);
        s.ips_ok = (ic[0] == 1'b0); s.ipd_ok = 1'b0;
        s.ps_ok = 1'b0; s.pd_ok = (lc[0] == 1'b0);
        s.sp_ok = ((ic + lc) % 2 == 0);
        send(s, "R4 R5 R6 defaults");
      end
    idle(4);

    // R9: flow and reverse direction, symmetric on
    for (int i = 0; i < 6; i++) begin
      s = rnd_stim();
      s.cmd[30] = 1'b1;
      s.pd_ok = (i % 2 == 0);
      r = s;
      r.ips = s.ipd; r.ipd = s.ips; r.ps = s.pd; r.pd = s.ps;
      r.ps_ok = s.pd_ok; r.pd_ok = s.ps_ok;
      send(s, "R9 forward");
      send(r, "R9 reverse");
      check(model(s) == model(r), "R9 model symmetric", model(r), model(s));
    end
    idle(4);

    // R7: large shifts leave few hash bits
    s = rnd_stim(); s.cmd = {2'b00, 6'd63, 24'hFFFFFF}; s.base = 24'h000000;
    send(s, "R7 shift 63");
    s = rnd_stim(); s.cmd = {2'b00, 6'd40, 24'hFFFFFF}; s.base = 24'h000000;
    send(s, "R7 shift 40");
    s = rnd_stim(); s.cmd = {2'b00, 6'd0, 24'hFFFFFF}; s.base = 24'h000000;
    send(s, "R7 shift 0");
    idle(4);

    // R10: configuration changed right after the key is taken
    s = rnd_stim();
    send(s, "R10 config after issue");
    @(negedge clk);
    in_valid = 1'b0;
    cur.cmd = 32'h3F00_0FFF; cur.base = 24'hABC000; cur.sel = '0;
    cur.d0 = 32'hFFFF_FFFF;
    idle(5);

    // R2: every key produced exactly one result
    check(expq.size() == 0, "R2 scoreboard drained", 24'(expq.size()), 24'h0);
    check(got == sent, "R2 result count", 24'(got), 24'(sent));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule